// File: doc/BRIEF.md
# Execution Context Summary Unit

This block keeps one cached word that tells the rest of a core what execution context it is in. The word holds the architectural mode and submode, the current privilege level, the paging and protection enables, and 2-bit size codes for operand, address and stack width. Logic downstream reads one register instead of re-deriving the context from five separate control registers on every access.

The unit holds its own copy of the five source registers: the extended-feature word, control word 0, the code-segment attribute word, the stack-segment attribute word and the flags word. Each source has a write strobe and a data bus. The summary is recomputed and loaded on the clock edge where any source is written. It is also recomputed when the refresh strobe is raised, which stands for a write to the summary word itself. Such a write carries no data, and the recompute uses the sources as they are held. A source written in the same cycle as the recompute contributes its new value. Between those events the summary does not change.

Top module: `ctx_summary_unit`

## Requirements
- R1: While reset (`rst_n` low) is sampled at a clock edge, the summary becomes all zeros. The held source copies also become all zeros.
- R2: Summary layout: bit 0 mode (0 Legacy, 1 Long), bits 3:1 submode (0 Long64, 1 Compat, 2 Protected, 3 Virtual-8086, 4 Real), bits 5:4 privilege, bit 6 paging, bit 7 protection, bits 9:8 default operand, bits 11:10 alternate operand, bits 13:12 default address, bits 15:14 alternate address, bits 17:16 stack. When long-mode-active (feature bit 10) is 1, the mode is Long. The submode is then Long64 if the code long bit (code attribute bit 3) is 1, and Compat if it is 0. In Long mode, control bit 0 and flags bit 17 are ignored.
- R3: When long-mode-active is 0, the mode is Legacy. The submode is Real if the protection enable (control bit 0) is 0. Otherwise it is Virtual-8086 if the flags bit 17 is 1, and Protected if that bit is 0. In Legacy mode the code long bit is ignored.
- R4: Privilege equals code attribute bits 1:0. Paging equals control bit 31. Protection equals control bit 0.
- R5: Operand codes are default 2 and alternate 1 when the submode is Long64 or the code default-size bit (code attribute bit 2) is 1. Otherwise they are default 1 and alternate 2.
- R6: Address codes are default 3 and alternate 2 in Long64. Otherwise they are default 2 and alternate 1 when the code default-size bit is 1, and default 1 and alternate 2 when it is 0.
- R7: The stack code is 3 in Long64. Otherwise it is 2 when the stack default-size bit (stack attribute bit 2) is 1, and 1 when it is 0.
- R8: A refresh pulse loads, one edge later, the value decoded from the currently held sources. No source data bus affects that value.
- R9: A write to a single source updates the summary at the same clock edge as the write. The decode uses the newly written value of that source and the held values of the others.
- R10: When no strobe is high, the summary stays unchanged, whatever is on the source data buses.
- R11: Writes to several sources in the same cycle all apply their new values to one recompute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| feat_we | input | 1 | Extended-feature word write strobe |
| feat_wdata | input | FEAT_W | Extended-feature write data |
| ctl_we | input | 1 | Control word 0 write strobe |
| ctl_wdata | input | CTL_W | Control word 0 write data |
| cattr_we | input | 1 | Code attribute write strobe |
| cattr_wdata | input | ATTR_W | Code attribute write data |
| sattr_we | input | 1 | Stack attribute write strobe |
| sattr_wdata | input | ATTR_W | Stack attribute write data |
| flags_we | input | 1 | Flags word write strobe |
| flags_wdata | input | FLAGS_W | Flags write data |
| refresh | input | 1 | Recompute from held sources (summary write, data discarded) |
| summary | output | 18 | Cached context summary word |

## Verification
The hardest case to reach is a refresh that must be told apart from a source write. A refresh that follows a full source write reloads the same value, so it proves nothing. The stimulus uses the state right after reset instead. There the summary is zero while the held sources decode to a nonzero Real-mode word. The bench first puts data on every source bus with no strobes and checks that the zero holds. It then pulses refresh and checks that the Real-mode word appears and that the bus data is ignored. Single-source writes are made on top of a known table state, so each expected word differs from the old one only in the fields that the write should change.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  typedef enum logic [2:0] {
    SUB_LONG64 = 3'd0,
    SUB_COMPAT = 3'd1,
    SUB_PROT   = 3'd2,
    SUB_V86    = 3'd3,
    SUB_REAL   = 3'd4
  } submode_e;

  // Bit order matches the summary layout, MSB first.
  typedef struct packed {
    logic [1:0] stk;
    logic [1:0] alt_addr;
    logic [1:0] def_addr;
    logic [1:0] alt_op;
    logic [1:0] def_op;
    logic       prot;
    logic       paging;
    logic [1:0] cpl;
    submode_e   sub;
    logic       mode;
  } summary_t;

  localparam int SUM_W = $bits(summary_t);

  // Fields pulled out of the source words.
  typedef struct packed {
    logic       lma;
    logic       pe;
    logic       pg;
    logic       vm;
    logic [1:0] cs_cpl;
    logic       cs_def;
    logic       cs_long;
    logic       ss_def;
  } src_view_t;

  function automatic submode_e pick_submode(input src_view_t v);
    if (v.lma)      return v.cs_long ? SUB_LONG64 : SUB_COMPAT;
    else if (!v.pe) return SUB_REAL;
    else            return v.vm ? SUB_V86 : SUB_PROT;
  endfunction

  // Returns {default, alternate}.
  function automatic logic [3:0] op_codes(input logic is64, input logic cs_def);
    return (is64 || cs_def) ? {2'd2, 2'd1} : {2'd1, 2'd2};
  endfunction

  function automatic logic [3:0] addr_codes(input logic is64, input logic cs_def);
    if (is64)        return {2'd3, 2'd2};
    else if (cs_def) return {2'd2, 2'd1};
    else             return {2'd1, 2'd2};
  endfunction

  function automatic logic [1:0] stack_code(input logic is64, input logic ss_def);
    if (is64)        return 2'd3;
    else if (ss_def) return 2'd2;
    else             return 2'd1;
  endfunction

endpackage

// File: rtl/ctx_src_slot.sv
// One held source register; exposes the value a recompute must use this cycle.
module ctx_src_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] view
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  held_q <= '0;
    else if (we) held_q <= wdata;
  end

  assign view = we ? wdata : held_q;
endmodule

// File: rtl/ctx_mode_decode.sv
module ctx_mode_decode
  import ctx_pkg::*;
(
  input  src_view_t v,
  output summary_t  s
);
  submode_e   sub;
  logic       is64;
  logic [3:0] op_pair;
  logic [3:0] ad_pair;

  always_comb begin
    sub     = pick_submode(v);
    is64    = (sub == SUB_LONG64);
    op_pair = op_codes(is64, v.cs_def);
    ad_pair = addr_codes(is64, v.cs_def);
    s.mode     = v.lma;
    s.sub      = sub;
    s.cpl      = v.cs_cpl;
    s.paging   = v.pg;
    s.prot     = v.pe;
    s.def_op   = op_pair[3:2];
    s.alt_op   = op_pair[1:0];
    s.def_addr = ad_pair[3:2];
    s.alt_addr = ad_pair[1:0];
    s.stk      = stack_code(is64, v.ss_def);
  end
endmodule

// File: rtl/ctx_summary_reg.sv
module ctx_summary_reg
  import ctx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  summary_t next_sum,
  output summary_t sum_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    sum_q <= '0;
    else if (load) sum_q <= next_sum;
  end
endmodule

// File: rtl/ctx_summary_unit.sv
module ctx_summary_unit
  import ctx_pkg::*;
#(
  parameter int FEAT_W   = 64,
  parameter int LMA_POS  = 10,
  parameter int CTL_W    = 32,
  parameter int PE_POS   = 0,
  parameter int PG_POS   = 31,
  parameter int ATTR_W   = 16,
  parameter int CPL_LSB  = 0,
  parameter int DEF_POS  = 2,
  parameter int LONG_POS = 3,
  parameter int FLAGS_W  = 32,
  parameter int VM_POS   = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               feat_we,
  input  logic [FEAT_W-1:0]  feat_wdata,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_wdata,
  input  logic               cattr_we,
  input  logic [ATTR_W-1:0]  cattr_wdata,
  input  logic               sattr_we,
  input  logic [ATTR_W-1:0]  sattr_wdata,
  input  logic               flags_we,
  input  logic [FLAGS_W-1:0] flags_wdata,
  input  logic               refresh,
  output logic [SUM_W-1:0]   summary
);
  logic [FEAT_W-1:0]  feat_v;
  logic [CTL_W-1:0]   ctl_v;
  logic [ATTR_W-1:0]  cattr_v;
  logic [ATTR_W-1:0]  sattr_v;
  logic [FLAGS_W-1:0] flags_v;

  ctx_src_slot #(.W(FEAT_W))  u_feat  (.clk, .rst_n, .we(feat_we),  .wdata(feat_wdata),  .view(feat_v));
  ctx_src_slot #(.W(CTL_W))   u_ctl   (.clk, .rst_n, .we(ctl_we),   .wdata(ctl_wdata),   .view(ctl_v));
  ctx_src_slot #(.W(ATTR_W))  u_cattr (.clk, .rst_n, .we(cattr_we), .wdata(cattr_wdata), .view(cattr_v));
  ctx_src_slot #(.W(ATTR_W))  u_sattr (.clk, .rst_n, .we(sattr_we), .wdata(sattr_wdata), .view(sattr_v));
  ctx_src_slot #(.W(FLAGS_W)) u_flags (.clk, .rst_n, .we(flags_we), .wdata(flags_wdata), .view(flags_v));

  src_view_t view_s;
  always_comb begin
    view_s.lma     = feat_v[LMA_POS];
    view_s.pe      = ctl_v[PE_POS];
    view_s.pg      = ctl_v[PG_POS];
    view_s.vm      = flags_v[VM_POS];
    view_s.cs_cpl  = cattr_v[CPL_LSB +: 2];
    view_s.cs_def  = cattr_v[DEF_POS];
    view_s.cs_long = cattr_v[LONG_POS];
    view_s.ss_def  = sattr_v[DEF_POS];
  end

  // Named events for the checker.
  logic     src_write_evt;
  logic     load_evt;
  summary_t next_sum;
  summary_t sum_q;

  assign src_write_evt = feat_we | ctl_we | cattr_we | sattr_we | flags_we;
  assign load_evt      = src_write_evt | refresh;

  ctx_mode_decode u_dec (.v(view_s), .s(next_sum));

  ctx_summary_reg u_reg (.clk, .rst_n, .load(load_evt), .next_sum(next_sum), .sum_q(sum_q));

  assign summary = sum_q;
endmodule

// File: rtl/ctx_summary_chk.sv
module ctx_summary_chk
  import ctx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       load_evt,
  input summary_t   next_sum,
  input logic [SUM_W-1:0] summary
);
  summary_t s;
  assign s = summary_t'(summary);

  logic loaded_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        loaded_q <= 1'b0;
    else if (load_evt) loaded_q <= 1'b1;
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> summary == '0);

  assert_load_takes_decode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> summary == $past(next_sum));

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(summary));

  assert_op_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |-> (s.def_op != s.alt_op) && (s.def_op inside {2'd1, 2'd2}));

  assert_long64_sizes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && s.sub == SUB_LONG64) |-> (s.def_addr == 2'd3 && s.stk == 2'd3 && s.mode));

  assert_mode_sub_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |-> (s.mode == (s.sub inside {SUB_LONG64, SUB_COMPAT})));
endmodule

bind ctx_summary_unit ctx_summary_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_evt (load_evt),
  .next_sum (next_sum),
  .summary  (summary)
);

// File: tb/tb_ctx_summary_unit.sv
module tb_ctx_summary_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat_we = 0, ctl_we = 0, cattr_we = 0, sattr_we = 0, flags_we = 0, refresh = 0;
  logic [63:0] feat_wdata = '0;
  logic [31:0] ctl_wdata = '0;
  logic [15:0] cattr_wdata = '0;
  logic [15:0] sattr_wdata = '0;
  logic [31:0] flags_wdata = '0;
  logic [17:0] summary;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_summary_unit dut (
    .clk, .rst_n, .feat_we, .feat_wdata, .ctl_we, .ctl_wdata,
    .cattr_we, .cattr_wdata, .sattr_we, .sattr_wdata,
    .flags_we, .flags_wdata, .refresh, .summary
  );

  // {lma,pe,pg,vm, cpl[2], cs_def,cs_long,ss_def, mode, sub[3], dop,aop,dad,aad,stk}
  localparam logic [22:0] VEC [0:7] = '{
    23'b0000_00_000_0_100_01_10_01_10_01, // real, all zero
    23'b0100_11_101_0_010_10_01_10_01_10, // protected 32-bit
    23'b0111_11_000_0_011_01_10_01_10_01, // virtual-8086
    23'b1110_00_010_1_000_10_01_11_10_11, // long 64
    23'b1110_10_100_1_001_10_01_10_01_01, // compat 32, stack 16
    23'b1111_01_001_1_001_01_10_01_10_10, // compat 16, vm ignored
    23'b0011_01_111_0_100_10_01_10_01_10, // real, vm and long bit ignored
    23'b1000_00_111_1_000_10_01_11_10_11  // 64 with pe clear
  };

  function automatic logic [17:0] pack_exp(input logic [22:0] e);
    // e[13:0] = mode,sub,dop,aop,dad,aad,stk ; stimulus in e[22:14]
    return {e[1:0], e[3:2], e[5:4], e[7:6], e[9:8],
            e[21], e[20], e[18:17], e[12:10], e[13]};
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: summary=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_all(input logic [22:0] e);
    @(negedge clk);
    feat_we = 1; ctl_we = 1; cattr_we = 1; sattr_we = 1; flags_we = 1;
    feat_wdata  = 64'(e[22]) << 10;
    ctl_wdata   = {e[20], 30'd0, e[21]};
    flags_wdata = 32'(e[19]) << 17;
    cattr_wdata = {12'd0, e[15], e[16], e[18:17]};
    sattr_wdata = {13'd0, e[14], 2'd0};
    @(negedge clk);
    feat_we = 0; ctl_we = 0; cattr_we = 0; sattr_we = 0; flags_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: summary=%h expected=done", summary);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", summary, 18'd0);
    rst_n = 1;

    // R10: data without strobes has no effect
    @(negedge clk);
    feat_wdata = '1; ctl_wdata = '1; cattr_wdata = '1; sattr_wdata = '1; flags_wdata = '1;
    repeat (2) @(negedge clk);
    check("R10 idle buses", summary, 18'd0);

    // R8: refresh uses held (zero) sources, not bus data
    refresh = 1;
    @(negedge clk);
    refresh = 0;
    check("R8 refresh", summary, pack_exp(VEC[0]));

    // R2..R7, R11: table of simultaneous writes
    for (int i = 0; i < 8; i++) begin
      drive_all(VEC[i]);
      check($sformatf("R2-7/R11 vec%0d", i), summary, pack_exp(VEC[i]));
    end

    // Rebuild long-64 state, then single-source writes (R9)
    drive_all(VEC[3]);
    @(negedge clk);
    cattr_we = 1; cattr_wdata = 16'h0006; // cpl 2, def 1, long 0
    @(negedge clk);
    cattr_we = 0;
    // compat32: mode1 sub1 cpl2 pg1 pe1 op 2/1 addr 2/1 stack 1
    check("R9 code attr write", summary, {2'd1, 2'd1, 2'd2, 2'd1, 2'd2, 1'b1, 1'b1, 2'd2, 3'd1, 1'b1});
    check("R5 R6 R7 compat", summary[17:8], {2'd1, 2'd1, 2'd2, 2'd1, 2'd2});

    sattr_we = 1; sattr_wdata = 16'h0004;
    @(negedge clk);
    sattr_we = 0;
    check("R7 stack attr write", summary[17:16], 2'd2);

    feat_we = 1; feat_wdata = '0;
    @(negedge clk);
    feat_we = 0;
    check("R3 R9 leave long", summary[3:0], {3'd2, 1'b0});

    flags_we = 1; flags_wdata = 32'h0002_0000;
    @(negedge clk);
    flags_we = 0;
    check("R3 vm set", summary[3:1], 3'd3);

    ctl_we = 1; ctl_wdata = 32'h0;
    @(negedge clk);
    ctl_we = 0;
    check("R4 ctl clear", summary[7:1], {1'b0, 1'b0, 2'd2, 3'd4});

    // R10 again after nonzero state
    ctl_wdata = '1; flags_wdata = '0;
    repeat (3) @(negedge clk);
    check("R10 hold", summary[7:1], {1'b0, 1'b0, 2'd2, 3'd4});

    // R1 reset from nonzero state
    rst_n = 0;
    @(negedge clk);
    check("R1 reset again", summary, 18'd0);
    rst_n = 1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule